// File: doc/BRIEF.md
# Deferred-Address Configuration Register Bank

This block sits in front of a serial packet decoder. It holds the decoder's settings and feeds it one data bit at a time. Three host ports can reach it. Each port carries a valid flag, an 8-bit data value and an 8-bit register address. In every valid cycle the data is written to the register named by the address of the previous valid cycle. The address that comes with the data only names the target of the next write. Because of this deferred addressing, a host streams bits by presenting address 0x00 together with each bit. The first bit is preceded by one valid cycle that only sets up the address.

The bank holds eight byte-addressed registers:
- a serial-bit register;
- an input/output routing register;
- a 6-bit channel register;
- a 40-bit sync pattern made of a preamble byte and a four-byte access address.

The routing register picks which host port drives the bank. It also picks, independently, which host port receives the decoder's status line. The decoder logic itself is not part of this block.

Top module: `cfg_regbank`

## Requirements
- R1: While reset is high, and in the first cycle after it, the bank holds these values. The serial bit is 0 and the bit strobe is low. The channel is 37 and the sync pattern is 0x558E89BED6. The routing register is 0, so port A drives the bank and receives the status.
- R2: The selected port's data in a valid cycle is written to the register addressed in that port's previous valid cycle; cycles without valid change nothing. The first valid cycle after reset writes no register.
- R3: A write to address 0x00 sets the serial bit to data bit 0 from the next cycle. Data bits [7:1] have no effect.
- R4: Each write to address 0x00 raises the bit strobe for exactly the one cycle that follows it. Writes to any other address leave the strobe low.
- R5: Bits [1:0] of the routing register (address 0x01) pick the input port: 00 selects port A, 01 port B, 10 port C and 11 port A. The new choice applies from the cycle after the write. Writes arriving on unselected ports have no effect.
- R6: Bits [3:2] of the routing register pick the status port with the same coding. The decoder status is copied to that port's status output in the same cycle, and the other status outputs are 0.
- R7: A write to address 0x02 sets the channel to data bits [5:0] from the next cycle.
- R8: Address 0x07 holds the preamble, which is sync pattern bits [39:32]. Addresses 0x06, 0x05, 0x04 and 0x03 hold the access address from its most significant to its least significant byte, which are sync bits [31:24], [23:16], [15:8] and [7:0].
- R9: A data write whose deferred address is 0x08 or above changes no register and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pa_vld | input | 1 | Port A valid |
| pa_data | input | 8 | Port A data |
| pa_addr | input | 8 | Port A address for the next write |
| pa_status | output | 1 | Decoder status routed to port A |
| pb_vld | input | 1 | Port B valid |
| pb_data | input | 8 | Port B data |
| pb_addr | input | 8 | Port B address for the next write |
| pb_status | output | 1 | Decoder status routed to port B |
| pc_vld | input | 1 | Port C valid |
| pc_data | input | 8 | Port C data |
| pc_addr | input | 8 | Port C address for the next write |
| pc_status | output | 1 | Decoder status routed to port C |
| dec_status_i | input | 1 | Status line from the decoder |
| dec_bit_o | output | 1 | Serial bit to the decoder |
| dec_bit_vld_o | output | 1 | One-cycle strobe for a new serial bit |
| dec_chan_o | output | 6 | Channel setting |
| dec_sync_o | output | 40 | Sync pattern; the preamble is in bits [39:32] |

## Verification
The bench writes each input in a cycle and compares register outputs one clock edge later. A register takes its new value at the edge that ends the data cycle, and the strobe is high for the one cycle after that edge. A register is written by the data that arrives one valid cycle after its address. Status routing is combinational, so it is compared in the same cycle it is driven. A change to the routing register moves the input port and the status port only from the cycle after the write edge. The bench's reference model advances its own routing state at that same edge, so every comparison happens at the point where the design's result is due.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_HOSTS  = 3;
    localparam int SYNC_BYTES = 5;
    localparam int SYNC_W     = SYNC_BYTES * BYTE_W;
    localparam int CHAN_W     = 6;
    localparam int SEL_W      = 2;
    localparam int CFG_W      = 2 * SEL_W;

    localparam logic [BYTE_W-1:0] ADR_BIT     = 8'h00;
    localparam logic [BYTE_W-1:0] ADR_ROUTE   = 8'h01;
    localparam logic [BYTE_W-1:0] ADR_CHAN    = 8'h02;
    localparam logic [BYTE_W-1:0] ADR_SYNC_LO = 8'h03;
    localparam logic [BYTE_W-1:0] ADR_SYNC_HI = ADR_SYNC_LO + BYTE_W'(SYNC_BYTES - 1);
    localparam logic [BYTE_W-1:0] ADR_NONE    = 8'hFF;

    localparam logic [CHAN_W-1:0] CHAN_RST = CHAN_W'(37);
    localparam logic [SYNC_W-1:0] SYNC_RST = 40'h558E89BED6;

    typedef enum logic [SEL_W-1:0] {
        HOST_A = 2'd0,
        HOST_B = 2'd1,
        HOST_C = 2'd2
    } host_e;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] addr;
    } host_req_t;

    typedef struct packed {
        logic              we;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } reg_wr_t;

    // Unused code 11 falls back to port A.
    function automatic host_e sel_decode(input logic [SEL_W-1:0] code);
        case (code)
            2'b01:   return HOST_B;
            2'b10:   return HOST_C;
            default: return HOST_A;
        endcase
    endfunction

    function automatic logic addr_mapped(input logic [BYTE_W-1:0] a);
        return a <= ADR_SYNC_HI;
    endfunction

endpackage

// File: rtl/cfg_host_mux.sv
module cfg_host_mux
    import cfgbank_pkg::*;
#(
    parameter int HOSTS = NUM_HOSTS
) (
    input  host_req_t req_i [HOSTS],
    input  host_e     sel_i,
    output host_req_t req_o
);
    always_comb begin
        req_o = '0;
        for (int i = 0; i < HOSTS; i++) begin
            if (int'(sel_i) == i) begin
                req_o = req_i[i];
            end
        end
    end
endmodule

// File: rtl/cfg_addr_pipe.sv
module cfg_addr_pipe
    import cfgbank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_req_t req_i,
    output reg_wr_t   wr_o
);
    logic [BYTE_W-1:0] pend_q;

    // The address of one valid cycle aims the data of the next one.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= ADR_NONE;
        end else if (req_i.vld) begin
            pend_q <= req_i.addr;
        end
    end

    always_comb begin
        wr_o.we   = req_i.vld && addr_mapped(pend_q);
        wr_o.addr = pend_q;
        wr_o.data = req_i.data;
    end
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
    import cfgbank_pkg::*;
#(
    parameter int NBYTES = SYNC_BYTES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  reg_wr_t                  wr_i,
    output logic                     bit_o,
    output logic                     bit_vld_o,
    output logic [CHAN_W-1:0]        chan_o,
    output logic [NBYTES*BYTE_W-1:0] sync_o,
    output host_e                    in_sel_o,
    output host_e                    out_sel_o
);
    localparam logic [NBYTES*BYTE_W-1:0] SYNC_INIT = (NBYTES*BYTE_W)'(SYNC_RST);

    logic              bit_q;
    logic              bit_vld_q;
    logic [CHAN_W-1:0] chan_q;
    logic [CFG_W-1:0]  route_q;
    logic [BYTE_W-1:0] sync_q [NBYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q     <= 1'b0;
            bit_vld_q <= 1'b0;
            chan_q    <= CHAN_RST;
            route_q   <= '0;
        end else begin
            bit_vld_q <= wr_i.we && (wr_i.addr == ADR_BIT);
            if (wr_i.we && wr_i.addr == ADR_BIT) begin
                bit_q <= wr_i.data[0];
            end
            if (wr_i.we && wr_i.addr == ADR_ROUTE) begin
                route_q <= wr_i.data[CFG_W-1:0];
            end
            if (wr_i.we && wr_i.addr == ADR_CHAN) begin
                chan_q <= wr_i.data[CHAN_W-1:0];
            end
        end
    end

    for (genvar k = 0; k < NBYTES; k++) begin : g_sync
        localparam logic [BYTE_W-1:0] ADR_K = ADR_SYNC_LO + BYTE_W'(k);
        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q[k] <= SYNC_INIT[k*BYTE_W +: BYTE_W];
            end else if (wr_i.we && wr_i.addr == ADR_K) begin
                sync_q[k] <= wr_i.data;
            end
        end
        assign sync_o[k*BYTE_W +: BYTE_W] = sync_q[k];
    end

    assign bit_o     = bit_q;
    assign bit_vld_o = bit_vld_q;
    assign chan_o    = chan_q;
    assign in_sel_o  = sel_decode(route_q[SEL_W-1:0]);
    assign out_sel_o = sel_decode(route_q[CFG_W-1:SEL_W]);
endmodule

// File: rtl/cfg_status_route.sv
module cfg_status_route
    import cfgbank_pkg::*;
#(
    parameter int HOSTS = NUM_HOSTS
) (
    input  logic             status_i,
    input  host_e            sel_i,
    output logic [HOSTS-1:0] stat_o
);
    for (genvar i = 0; i < HOSTS; i++) begin : g_route
        assign stat_o[i] = status_i && (int'(sel_i) == i);
    end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfgbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pa_vld,
    input  logic [7:0]        pa_data,
    input  logic [7:0]        pa_addr,
    output logic              pa_status,
    input  logic              pb_vld,
    input  logic [7:0]        pb_data,
    input  logic [7:0]        pb_addr,
    output logic              pb_status,
    input  logic              pc_vld,
    input  logic [7:0]        pc_data,
    input  logic [7:0]        pc_addr,
    output logic              pc_status,
    input  logic              dec_status_i,
    output logic              dec_bit_o,
    output logic              dec_bit_vld_o,
    output logic [5:0]        dec_chan_o,
    output logic [39:0]       dec_sync_o
);
    host_req_t             host_req [NUM_HOSTS];
    host_req_t             sel_req;
    reg_wr_t               wr;
    host_e                 in_sel;
    host_e                 out_sel;
    logic [NUM_HOSTS-1:0]  host_stat;

    assign host_req[0] = '{vld: pa_vld, data: pa_data, addr: pa_addr};
    assign host_req[1] = '{vld: pb_vld, data: pb_data, addr: pb_addr};
    assign host_req[2] = '{vld: pc_vld, data: pc_data, addr: pc_addr};

    cfg_host_mux #(.HOSTS(NUM_HOSTS)) u_mux (
        .req_i (host_req),
        .sel_i (in_sel),
        .req_o (sel_req)
    );

    cfg_addr_pipe u_pipe (
        .clk   (clk),
        .rst   (rst),
        .req_i (sel_req),
        .wr_o  (wr)
    );

    cfg_reg_file #(.NBYTES(SYNC_BYTES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr),
        .bit_o     (dec_bit_o),
        .bit_vld_o (dec_bit_vld_o),
        .chan_o    (dec_chan_o),
        .sync_o    (dec_sync_o),
        .in_sel_o  (in_sel),
        .out_sel_o (out_sel)
    );

    cfg_status_route #(.HOSTS(NUM_HOSTS)) u_route (
        .status_i (dec_status_i),
        .sel_i    (out_sel),
        .stat_o   (host_stat)
    );

    assign pa_status = host_stat[0];
    assign pb_status = host_stat[1];
    assign pc_status = host_stat[2];
endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk
    import cfgbank_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input reg_wr_t     wr,
    input logic        bit_vld,
    input logic        bit_val,
    input logic [5:0]  chan,
    input logic [39:0] sync,
    input logic [2:0]  stat
);
    // R1
    reset_default_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (chan == CHAN_RST && sync == SYNC_RST && !bit_vld && !bit_val));

    // R4
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        bit_vld |-> $past(wr.we && wr.addr == ADR_BIT));

    // R4
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.we && wr.addr == ADR_BIT) |=> bit_vld);

    // R3
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |-> $stable(bit_val));

    // R3
    bit_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        bit_vld |-> (bit_val == $past(wr.data[0])));

    // R7
    chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr.we && wr.addr == ADR_CHAN) |-> $stable(chan));

    // R6
    one_status_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stat));
endmodule

bind cfg_regbank cfg_regbank_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr),
    .bit_vld (dec_bit_vld_o),
    .bit_val (dec_bit_o),
    .chan    (dec_chan_o),
    .sync    (dec_sync_o),
    .stat    (host_stat)
);

// File: tb/cfg_regbank_bench.sv
module cfg_regbank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pv [3];
    logic [7:0]  pd [3];
    logic [7:0]  pa [3];
    logic        st;
    logic        s_a, s_b, s_c;
    logic        dbit, dvld;
    logic [5:0]  dchan;
    logic [39:0] dsync;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    // reference state
    logic [7:0]  m_pend;
    logic        m_bit, m_vld;
    logic [5:0]  m_chan;
    logic [39:0] m_sync;
    logic [3:0]  m_route;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_regbank u_cfg_regbank (
        .clk(clk), .rst(rst),
        .pa_vld(pv[0]), .pa_data(pd[0]), .pa_addr(pa[0]), .pa_status(s_a),
        .pb_vld(pv[1]), .pb_data(pd[1]), .pb_addr(pa[1]), .pb_status(s_b),
        .pc_vld(pv[2]), .pc_data(pd[2]), .pc_addr(pa[2]), .pc_status(s_c),
        .dec_status_i(st),
        .dec_bit_o(dbit), .dec_bit_vld_o(dvld),
        .dec_chan_o(dchan), .dec_sync_o(dsync)
    );

    function automatic int port_of(input logic [1:0] code);
        if (code == 2'b01) return 1;
        if (code == 2'b10) return 2;
        return 0;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pend = 8'hFF; m_bit = 1'b0; m_vld = 1'b0;
        m_chan = 6'd37; m_sync = 40'h558E89BED6; m_route = 4'h0;
    endtask

    task automatic check_regs();
        chk("R3 serial bit", {63'd0, dbit}, {63'd0, m_bit});
        chk("R4 bit strobe", {63'd0, dvld}, {63'd0, m_vld});
        chk("R7 channel", {58'd0, dchan}, {58'd0, m_chan});
        chk("R8 sync pattern", {24'd0, dsync}, {24'd0, m_sync});
    endtask

    // One cycle: drive at the falling edge, check status now, registers after the next edge.
    task automatic step();
        int sp, op;
        logic v;
        logic [7:0] d;
        #1;
        op = port_of(m_route[3:2]);
        chk("R6 status to port A", {63'd0, s_a}, {63'd0, st && op == 0});
        chk("R6 status to port B", {63'd0, s_b}, {63'd0, st && op == 1});
        chk("R6 status to port C", {63'd0, s_c}, {63'd0, st && op == 2});
        sp = port_of(m_route[1:0]);
        v = pv[sp]; d = pd[sp];
        m_vld = 1'b0;
        if (v) begin
            if (m_pend == 8'h00) begin m_bit = d[0]; m_vld = 1'b1; end
            else if (m_pend == 8'h01) m_route = d[3:0];
            else if (m_pend == 8'h02) m_chan = d[5:0];
            else if (m_pend >= 8'h03 && m_pend <= 8'h07) m_sync[(m_pend - 8'h03) * 8 +: 8] = d;
            m_pend = pa[sp];
        end
        @(negedge clk);
        check_regs();
    endtask

    task automatic idle_all();
        for (int i = 0; i < 3; i++) begin
            pv[i] = 1'b0; pd[i] = 8'($urandom); pa[i] = 8'($urandom);
        end
        st = 1'b0;
    endtask

    task automatic drive_one(input int port, input logic [7:0] d, input logic [7:0] a, input logic s);
        idle_all();
        pv[port] = 1'b1; pd[port] = d; pa[port] = a; st = s;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_all();
        model_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: values held during reset
        chk("R1 channel in reset", {58'd0, dchan}, 64'd37);
        chk("R1 sync in reset", {24'd0, dsync}, 64'h558E89BED6);
        chk("R1 strobe in reset", {63'd0, dvld}, 64'd0);
        rst = 1'b0;
        st = 1'b1;
        #1;
        chk("R1 status on port A", {61'd0, s_c, s_b, s_a}, 64'd1);
        chk("R1 serial bit", {63'd0, dbit}, 64'd0);

        // R2: first valid after reset only loads the address
        drive_one(0, 8'h01, 8'h00, 1'b0);
        chk("R2 first valid writes nothing", {63'd0, dvld}, 64'd0);
        // R3: upper bits ignored, bit taken from data[0]
        drive_one(0, 8'hFF, 8'h00, 1'b0);
        chk("R3 bit from lsb", {63'd0, dbit}, 64'd1);
        drive_one(0, 8'hFE, 8'h05, 1'b0);
        chk("R3 upper bits ignored", {63'd0, dbit}, 64'd0);
        // R4: strobe drops after a write elsewhere
        drive_one(0, 8'hAB, 8'h02, 1'b0);
        chk("R4 no strobe on sync write", {63'd0, dvld}, 64'd0);
        chk("R8 addr 5 is sync bits 23:16", {56'd0, dsync[23:16]}, 64'hAB);
        // R7: only low six bits
        drive_one(0, 8'hFF, 8'h07, 1'b0);
        chk("R7 channel low bits", {58'd0, dchan}, 64'd63);
        drive_one(0, 8'h3C, 8'h03, 1'b0);
        chk("R8 preamble byte", {56'd0, dsync[39:32]}, 64'h3C);
        drive_one(0, 8'h5A, 8'h08, 1'b0);
        chk("R8 addr 3 is sync bits 7:0", {56'd0, dsync[7:0]}, 64'h5A);
        // R9: unmapped addresses
        drive_one(0, 8'h00, 8'hC3, 1'b0);
        chk("R9 addr 08 ignored", {24'd0, dsync}, {24'd0, m_sync});
        drive_one(0, 8'h01, 8'h01, 1'b1);
        chk("R9 addr C3 no strobe", {63'd0, dvld}, 64'd0);
        // R5/R6: input code 11 -> A, output 01 -> B
        drive_one(0, 8'h07, 8'h02, 1'b1);
        st = 1'b1; #1;
        chk("R6 status routed to B", {61'd0, s_c, s_b, s_a}, 64'd2);
        drive_one(1, 8'h11, 8'h02, 1'b1);
        drive_one(1, 8'h12, 8'h02, 1'b1);
        chk("R5 port B ignored", {58'd0, dchan}, {58'd0, m_chan});
        drive_one(0, 8'h09, 8'h01, 1'b0);
        chk("R5 code 11 used port A", {58'd0, dchan}, 64'd9);
        // route input to C, output to C
        drive_one(0, 8'h0A, 8'h00, 1'b1);
        drive_one(2, 8'h00, 8'h02, 1'b1);
        drive_one(2, 8'h15, 8'h00, 1'b1);
        chk("R5 port C write", {58'd0, dchan}, 64'h15);
        drive_one(2, 8'h01, 8'h00, 1'b1);
        chk("R4 strobe after data write", {63'd0, dvld}, 64'd1);
        drive_one(2, 8'h00, 8'h00, 1'b1);
        chk("R4 back-to-back strobe", {63'd0, dvld}, 64'd1);
        idle_all(); step();
        chk("R4 strobe lasts one cycle", {63'd0, dvld}, 64'd0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < 3; i++) begin
                pv[i] = 1'($urandom);
                pd[i] = 8'($urandom);
                pa[i] = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 10);
            end
            st = 1'($urandom);
            step();
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule